// File: doc/BRIEF.md
# Register-Programmed Two-Channel OPB Bridge Master

This block sits behind a host processor's APB-style register bus and issues single, non-burst transactions on two downstream OPB ports. Software picks a channel with a per-channel enable register and programs the channel's direction, size code and target address. For a write, it also loads the outgoing word into the channel's data register. It then writes the shared start register. Every channel that is enabled and idle raises its request and holds its address, direction, size and write data until the far side acknowledges it.

On acknowledge, a read stores the returned word in the channel's data register and the bus status register reads zero. If no acknowledge arrives within a fixed window, the transaction is abandoned and a nonzero timeout code is left in bus status. Either way, the channel's completion bit in the shared interrupt status register is set. Software clears that bit by writing a one to the same bit position of the interrupt clear register.

Top module: `apb_opb_bridge`

## Requirements
- R1: After reset all channel registers, both bus status registers and interrupt status read zero, and both OPB requests are low.
- R2: An APB write lands when psel_i, penable_i and pwrite_i are all high at a clock edge. Reads are combinational from paddr_i. Channel 0 maps enable, direction, size, address, bus status and data to 0x10, 0x14, 0x18, 0x1C, 0x80 and 0x84. Channel 1 maps the same registers to 0x28, 0x2C, 0x30, 0x34, 0x8C and 0x90. Enable and direction keep bit 0, size keeps bits 1:0, and address and data keep all 32 bits. Each reads back the last value written, with unused bits reading zero. Bus status is read-only.
- R3: A write of bit 0 = 1 to offset 0x04 starts a transaction on every channel that is enabled and idle. From the next cycle that channel's request is high, with the programmed address, size code, and read-not-write equal to the direction bit (1 = read).
- R4: At the edge where a busy channel sees its acknowledge high, the request drops and bus status is zero. For a read, the data register then holds the acknowledged word.
- R5: Completion of channel 0 sets interrupt status bit 16, and completion of channel 1 sets bit 17, at the completion edge. Interrupt status is read at 0x48.
- R6: Writing offset 0x40 clears each interrupt status bit 16 or 17 whose write-data bit is 1. Zero bits leave status unchanged, and a completion in the same cycle wins over the clear.
- R7: A busy channel with no acknowledge ends at the 256th edge after its start edge. Its request drops, its bus status reads 0x00000001 and its completion bit is set.
- R8: A start write to a channel that is already busy is ignored, and the running timeout window is not restarted.
- R9: A start write while neither channel is enabled raises no request and leaves interrupt status unchanged.
- R10: For a write transaction (direction 0), the data register drives the channel's write data. Its value is unchanged after the acknowledge.
- R11: An acknowledge on an idle channel does not change its data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Register bus select |
| penable_i | input | 1 | Register bus access phase |
| pwrite_i | input | 1 | Register bus write |
| paddr_i | input | 8 | Register byte offset |
| pwdata_i | input | 32 | Register write data |
| prdata_o | output | 32 | Register read data (combinational) |
| opb_req_o | output | 2 | Per-channel transaction request |
| opb_rnw_o | output | 2 | Per-channel read-not-write |
| opb_size_o | output | 2x2 | Per-channel size code |
| opb_addr_o | output | 2x32 | Per-channel target address |
| opb_wdata_o | output | 2x32 | Per-channel write data |
| opb_ack_i | input | 2 | Per-channel acknowledge |
| opb_rdata_i | input | 2x32 | Per-channel returned data |

## Verification
A register write takes effect at the edge where the access phase is sampled, so readback is checked at the next falling edge. Reads are combinational and take zero cycles. The request is due one cycle after the start edge. Captured data, bus status and the completion bit are all due at the acknowledge edge itself. The bench drives acknowledge on a falling edge and checks at the following falling edge. For the timeout, the bench counts rising edges from the start edge. It checks that the request is still high after edge 255 and that it has dropped, with the timeout code and completion bit present, after edge 256.

// File: rtl/obr_pkg.sv
package obr_pkg;
  localparam int NCH    = 2;
  localparam int DW     = 32;
  localparam int AW     = 8;
  localparam int IRQ_LSB = 16;

  localparam logic [AW-1:0] OFF_TRIG  = 8'h04;
  localparam logic [AW-1:0] OFF_ICLR  = 8'h40;
  localparam logic [AW-1:0] OFF_ISTAT = 8'h48;

  localparam logic [DW-1:0] STAT_TIMEOUT = 32'h0000_0001;

  typedef enum logic [2:0] {
    CR_NONE, CR_SEL, CR_DIR, CR_SIZE, CR_ADDR, CR_DATA, CR_STAT
  } creg_e;

  typedef struct packed {
    logic [AW-1:0] sel;
    logic [AW-1:0] dir;
    logic [AW-1:0] size;
    logic [AW-1:0] addr;
    logic [AW-1:0] stat;
    logic [AW-1:0] data;
  } chan_map_t;

  function automatic chan_map_t chan_map(int ch);
    chan_map_t m;
    if (ch == 0) m = '{8'h10, 8'h14, 8'h18, 8'h1C, 8'h80, 8'h84};
    else         m = '{8'h28, 8'h2C, 8'h30, 8'h34, 8'h8C, 8'h90};
    return m;
  endfunction

  function automatic creg_e decode(logic [AW-1:0] a, chan_map_t m);
    creg_e r;
    r = CR_NONE;
    if (a == m.sel)  r = CR_SEL;
    if (a == m.dir)  r = CR_DIR;
    if (a == m.size) r = CR_SIZE;
    if (a == m.addr) r = CR_ADDR;
    if (a == m.stat) r = CR_STAT;
    if (a == m.data) r = CR_DATA;
    return r;
  endfunction
endpackage

// File: rtl/obr_chan_seq.sv
module obr_chan_seq
  import obr_pkg::*;
#(
  parameter int TO_CYCLES = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  creg_e         reg_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          trig_i,
  output logic          sel_o,
  output logic          dir_o,
  output logic [1:0]    size_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [DW-1:0] stat_o,
  output logic          done_o,
  output logic          req_o,
  output logic          rnw_o,
  output logic [1:0]    opb_size_o,
  output logic [DW-1:0] opb_addr_o,
  output logic [DW-1:0] opb_wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i
);
  localparam int CW = (TO_CYCLES > 1) ? $clog2(TO_CYCLES) : 1;
  localparam logic [CW-1:0] LIM = CW'(TO_CYCLES - 1);

  logic          sel_q, dir_q, busy_q;
  logic [1:0]    size_q;
  logic [DW-1:0] addr_q, data_q, stat_q;
  logic [CW-1:0] cnt_q;
  logic          expire;

  assign expire = busy_q && !ack_i && (cnt_q == LIM);
  assign done_o = busy_q && (ack_i || cnt_q == LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      dir_q  <= 1'b0;
      size_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      stat_q <= '0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_i) begin
        case (reg_i)
          CR_SEL:  sel_q  <= wdata_i[0];
          CR_DIR:  dir_q  <= wdata_i[0];
          CR_SIZE: size_q <= wdata_i[1:0];
          CR_ADDR: addr_q <= wdata_i;
          CR_DATA: data_q <= wdata_i;
          default: ;
        endcase
      end
      if (!busy_q) begin
        if (trig_i && sel_q) begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          stat_q <= '0;
        end
      end else if (ack_i) begin
        busy_q <= 1'b0;
        if (dir_q) data_q <= rdata_i;
      end else if (cnt_q == LIM) begin
        busy_q <= 1'b0;
        stat_q <= STAT_TIMEOUT;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign sel_o       = sel_q;
  assign dir_o       = dir_q;
  assign size_o      = size_q;
  assign addr_o      = addr_q;
  assign data_o      = data_q;
  assign stat_o      = stat_q;
  assign req_o       = busy_q;
  assign rnw_o       = dir_q;
  assign opb_size_o  = size_q;
  assign opb_addr_o  = addr_q;
  assign opb_wdata_o = data_q;

  AST_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && trig_i && sel_q |=> req_o); // R3
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i && !expire |=> req_o); // R3
  AST_ACK_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && ack_i |=> !req_o && stat_o == '0); // R4
  AST_TO_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !req_o && stat_o != '0); // R7
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && trig_i && !ack_i && !expire |=> cnt_q == $past(cnt_q) + 1'b1); // R8
  AST_NOSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && !sel_q |=> !req_o); // R9
  AST_IDLE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o && ack_i && !wr_i |=> $stable(data_o)); // R11
endmodule

// File: rtl/obr_irq.sv
module obr_irq
  import obr_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] done_i,
  input  logic           clr_i,
  input  logic [NCH-1:0] clr_mask_i,
  output logic [DW-1:0]  status_o
);
  logic [NCH-1:0] pend_q;

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        pend_q[i] <= 1'b0;
      else if (done_i[i])                 pend_q[i] <= 1'b1;
      else if (clr_i && clr_mask_i[i])    pend_q[i] <= 1'b0;
    end

    AST_IRQ_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_i[i] |=> status_o[IRQ_LSB+i]); // R5
    AST_IRQ_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && clr_mask_i[i] && !done_i[i] |=> !status_o[IRQ_LSB+i]); // R6
    AST_IRQ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_i[i] && !(clr_i && clr_mask_i[i]) |=> $stable(status_o[IRQ_LSB+i])); // R6
  end

  always_comb begin
    status_o = '0;
    status_o[IRQ_LSB +: NCH] = pend_q;
  end
endmodule

// File: rtl/apb_opb_bridge.sv
module apb_opb_bridge
  import obr_pkg::*;
#(
  parameter int TO_CYCLES = 256
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    psel_i,
  input  logic                    penable_i,
  input  logic                    pwrite_i,
  input  logic [AW-1:0]           paddr_i,
  input  logic [DW-1:0]           pwdata_i,
  output logic [DW-1:0]           prdata_o,
  output logic [NCH-1:0]          opb_req_o,
  output logic [NCH-1:0]          opb_rnw_o,
  output logic [NCH-1:0][1:0]     opb_size_o,
  output logic [NCH-1:0][DW-1:0]  opb_addr_o,
  output logic [NCH-1:0][DW-1:0]  opb_wdata_o,
  input  logic [NCH-1:0]          opb_ack_i,
  input  logic [NCH-1:0][DW-1:0]  opb_rdata_i
);
  logic wr_en, trig, clr;
  logic [DW-1:0] irq_st;
  logic [NCH-1:0] done, sel, dir;
  logic [NCH-1:0][1:0] size;
  logic [NCH-1:0][DW-1:0] addr, data, stat;
  creg_e idx [NCH];

  assign wr_en = psel_i && penable_i && pwrite_i;
  assign trig  = wr_en && (paddr_i == OFF_TRIG) && pwdata_i[0];
  assign clr   = wr_en && (paddr_i == OFF_ICLR);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign idx[c] = decode(paddr_i, chan_map(c));

    obr_chan_seq #(.TO_CYCLES(TO_CYCLES)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_en),
      .reg_i       (idx[c]),
      .wdata_i     (pwdata_i),
      .trig_i      (trig),
      .sel_o       (sel[c]),
      .dir_o       (dir[c]),
      .size_o      (size[c]),
      .addr_o      (addr[c]),
      .data_o      (data[c]),
      .stat_o      (stat[c]),
      .done_o      (done[c]),
      .req_o       (opb_req_o[c]),
      .rnw_o       (opb_rnw_o[c]),
      .opb_size_o  (opb_size_o[c]),
      .opb_addr_o  (opb_addr_o[c]),
      .opb_wdata_o (opb_wdata_o[c]),
      .ack_i       (opb_ack_i[c]),
      .rdata_i     (opb_rdata_i[c])
    );
  end

  obr_irq u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .clr_i      (clr),
    .clr_mask_i (pwdata_i[IRQ_LSB +: NCH]),
    .status_o   (irq_st)
  );

  always_comb begin
    prdata_o = '0;
    if (paddr_i == OFF_ISTAT) prdata_o = irq_st;
    for (int c = 0; c < NCH; c++) begin
      case (idx[c])
        CR_SEL:  prdata_o = {{(DW-1){1'b0}}, sel[c]};
        CR_DIR:  prdata_o = {{(DW-1){1'b0}}, dir[c]};
        CR_SIZE: prdata_o = {{(DW-2){1'b0}}, size[c]};
        CR_ADDR: prdata_o = addr[c];
        CR_DATA: prdata_o = data[c];
        CR_STAT: prdata_o = stat[c];
        default: ;
      endcase
    end
  end

  AST_NOSEL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig && sel == '0 && opb_req_o == '0 |=> $stable(irq_st)); // R9
endmodule

// File: tb/sim_apb_opb_bridge.sv
module sim_apb_opb_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, pen = 0, pwr = 0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic [1:0] req, rnw, ack = '0;
  logic [1:0][1:0] size;
  logic [1:0][31:0] addr, wdata, rdata = '0;
  int nchk = 0, nfail = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  apb_opb_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(pen), .pwrite_i(pwr),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .opb_req_o(req), .opb_rnw_o(rnw), .opb_size_o(size), .opb_addr_o(addr),
    .opb_wdata_o(wdata), .opb_ack_i(ack), .opb_rdata_i(rdata)
  );

  // {offset, write data, expected readback}
  localparam logic [71:0] VEC [10] = '{
    {8'h10, 32'hFFFF_FFF1, 32'h1},       {8'h14, 32'hF3F4_F515, 32'h1},
    {8'h18, 32'hF3F4_F51B, 32'h3},       {8'h1C, 32'hF3F4_F51C, 32'hF3F4_F51C},
    {8'h84, 32'h5A5A_1234, 32'h5A5A_1234}, {8'h80, 32'hFFFF_FFFF, 32'h0},
    {8'h28, 32'h0000_0000, 32'h0},       {8'h2C, 32'h0000_0002, 32'h0},
    {8'h34, 32'hA000_0000, 32'hA000_0000}, {8'h90, 32'h0BAD_F00D, 32'h0BAD_F00D}
  };

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwr = 1; pen = 0; paddr = a; pwdata = d;
    @(negedge clk); pen = 1;
    @(negedge clk); psel = 0; pen = 0; pwr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    psel = 1; pwr = 0; pen = 1; paddr = a;
    #1 d = prdata;
    psel = 0; pen = 0;
  endtask

  task automatic do_ack(int c, logic [31:0] d);
    @(negedge clk); ack[c] = 1; rdata[c] = d;
    @(negedge clk); ack[c] = 0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(8'h48, v); chk("R1 istat", v, 0);
    rd(8'h1C, v); chk("R1 addr0", v, 0);
    rd(8'h80, v); chk("R1 stat0", v, 0);
    chk("R1 req", {30'b0, req}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 register readback table
    foreach (VEC[i]) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R2 readback", v, VEC[i][31:0]);
    end

    // R3 R4 R5 read on channel 0
    wr(8'h14, 1); wr(8'h18, 3); wr(8'h1C, 32'hA000_0000);
    wr(8'h04, 1);
    chk("R3 req", {30'b0, req}, 2'b01);
    chk("R3 addr", addr[0], 32'hA000_0000);
    chk("R3 rnw", {31'b0, rnw[0]}, 1);
    chk("R3 size", {30'b0, size[0]}, 3);
    do_ack(0, 32'h152D_02C0);
    chk("R4 req drop", {30'b0, req}, 0);
    rd(8'h84, v); chk("R4 data", v, 32'h152D_02C0);
    rd(8'h80, v); chk("R4 stat", v, 0);
    rd(8'h48, v); chk("R5 bit16", v, 32'h0001_0000);

    // R11 ack while idle
    do_ack(0, 32'hDEAD_BEEF);
    rd(8'h84, v); chk("R11 idle ack", v, 32'h152D_02C0);

    // R6 clear
    wr(8'h40, 32'h0000_FFFF);
    rd(8'h48, v); chk("R6 zero mask", v, 32'h0001_0000);
    wr(8'h40, 32'h0001_0000);
    rd(8'h48, v); chk("R6 clear", v, 0);

    // R5 channel 1 read
    wr(8'h10, 0); wr(8'h28, 1); wr(8'h2C, 1); wr(8'h34, 32'h0000_0040);
    wr(8'h04, 1);
    chk("R3 ch1 req", {30'b0, req}, 2'b10);
    chk("R3 ch1 addr", addr[1], 32'h40);
    do_ack(1, 32'hCAFE_F00D);
    rd(8'h90, v); chk("R4 ch1 data", v, 32'hCAFE_F00D);
    rd(8'h48, v); chk("R5 bit17", v, 32'h0002_0000);

    // R10 write on channel 1
    wr(8'h2C, 0); wr(8'h90, 32'h0BAD_BEEF);
    wr(8'h04, 1);
    chk("R10 rnw", {31'b0, rnw[1]}, 0);
    chk("R10 wdata", wdata[1], 32'h0BAD_BEEF);
    do_ack(1, 32'h1111_2222);
    rd(8'h90, v); chk("R10 data kept", v, 32'h0BAD_BEEF);

    // R9 no channel enabled
    wr(8'h40, 32'h0003_0000);
    wr(8'h28, 0);
    wr(8'h04, 1);
    chk("R9 no req", {30'b0, req}, 0);
    @(negedge clk);
    chk("R9 no req later", {30'b0, req}, 0);
    rd(8'h48, v); chk("R9 istat", v, 0);

    // R7 R8 timeout with retrigger mid-window
    wr(8'h10, 1); wr(8'h14, 1);
    wr(8'h04, 1);
    t0 = cyc;
    repeat (90) @(negedge clk);
    wr(8'h04, 1);
    while (cyc < t0 + 255) @(negedge clk);
    chk("R8 req still up", {31'b0, req[0]}, 1);
    @(negedge clk);
    chk("R7 R8 req drops", {31'b0, req[0]}, 0);
    rd(8'h80, v); chk("R7 stat", v, 32'h1);
    rd(8'h48, v); chk("R7 irq", v, 32'h0001_0000);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule